// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead Time

This block is a synchronous controller for the four switches of a full bridge. It has two half-bridge legs, and each leg has an upper switch and a lower switch. For each leg it takes an upper command and a lower command. It also takes a disable input and two undervoltage flags that have already been qualified: one for the main supply and one for the high-side supplies. From these it produces four gate-enable outputs.

The overrides are resolved in a fixed order:
1. Disable.
2. Main-supply undervoltage.
3. Within a leg, the lower command wins over the upper command.

A gate turns off as soon as its command is removed. A gate turns on only after a programmable dead time, counted in clock cycles. An upper gate may also turn on only after the lower gate of the same leg has been off for that full time, and the reverse holds too.

When disable is released, both lower gates are driven on for a fixed number of cycles. This refreshes the bootstrap capacitors. Normal control then resumes. When a leg's upper command is tied high, the lower command alone steers that leg in complementary fashion.

All command and flag inputs pass through two-stage synchronizers. The dead-time count is registered from a static configuration input.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While disable is high, all four gate outputs are low, whatever the other inputs are.
- R2: While the main-supply undervoltage flag is high, all four gate outputs are low.
- R3: When both commands of a leg are high, the lower gate follows its command, the upper gate stays low, and the two gates of a leg are never high in the same cycle.
- R4: The high-side undervoltage flag forces only the upper gates low. A lower gate keeps following its own command while the flag is set.
- R5: A gate turns off exactly 3 clock edges after its command is removed: two synchronizer stages and one output register, with no dead-time delay.
- R6: From an idle leg, a gate turns on exactly D+3 clock edges after its command rises, where D is the programmed dead-time count.
- R7: When the upper command is held high, the lower command alone selects the active gate of the leg. The new gate rises D+1 edges after the old one falls, in both directions.
- R8: The two legs are independent. Activity on one leg never changes the gates of the other.
- R9: When disable goes from high to low, both lower gates turn on D+3 edges later and stay high for exactly REFRESH_CYC cycles. The upper gates stay low during this pulse.
- R10: If an upper command is pending when the refresh pulse ends, that upper gate rises D+1 edges after its lower gate falls.
- R11: Raising disable during a refresh pulse ends the pulse; the lower gates fall 3 edges later and stay low.
- R12: After reset all four gate outputs are low.
- R13: A dead-time count of zero gives a turn-on latency of 3 edges, equal to the turn-off latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dead_cyc | input | DT_W | Dead-time count in clock cycles (static configuration) |
| cmd_hi | input | 2 | Upper-switch command per leg (bit 0 = leg 0) |
| cmd_lo | input | 2 | Lower-switch command per leg |
| dis | input | 1 | Disable; high forces every gate low |
| uv_main | input | 1 | Main-supply undervoltage flag |
| uv_high | input | 1 | High-side supply undervoltage flag |
| gate_hi | output | 2 | Upper gate enables per leg |
| gate_lo | output | 2 | Lower gate enables per leg |

## Verification
Some behaviours are checked by the assertions on every cycle:
- No leg ever has both gates on.
- Synchronized disable or main undervoltage always yields all-low outputs on the next edge.
- High-side undervoltage always keeps the upper gates low.
- Every removed request reaches its gate within one register.
- An upper gate never rises while its lower gate is on or was on in the previous cycle.

Other behaviours can only be shown by the bench's directed scenarios, which measure latencies and pulse lengths in clock edges:
- The exact D+3 and D+1 turn-on latencies.
- The refresh pulse width and its abort when disable returns.
- The handover from the refresh pulse to a pending upper command.
- Leg independence and the zero dead-time case.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    localparam int NUM_LEGS = 2;

    // synchronized global condition flags
    typedef struct packed {
        logic dis;
        logic uv_main;
        logic uv_high;
    } hbg_flags_t;

    // requested gate state of one leg after override resolution
    typedef struct packed {
        logic hi;
        logic lo;
    } hbg_req_t;

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/hbg_refresh.sv
module hbg_refresh #(
    parameter int DT_W        = 10,
    parameter int REFRESH_CYC = 72
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dis_s,
    input  logic [DT_W-1:0] dead,
    output logic            refresh_o
);

    localparam int RW = $clog2(REFRESH_CYC + (1 << DT_W)) + 1;

    typedef struct packed {
        logic          dis_prev;
        logic [RW-1:0] cnt;
    } ref_state_t;

    ref_state_t st_q, st_d;
    logic       release_edge;

    always_comb begin
        release_edge = st_q.dis_prev && !dis_s;
        refresh_o    = release_edge || (st_q.cnt != '0);
        st_d          = st_q;
        st_d.dis_prev = dis_s;
        if (dis_s) begin
            st_d.cnt = '0;
        end else if (release_edge) begin
            // request length covers the dead time so the gate pulse is REFRESH_CYC wide
            st_d.cnt = RW'(REFRESH_CYC) + RW'(dead) - RW'(1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - RW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_REFRESH_QUIET_IN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dis_s) && dis_s |-> !refresh_o);  // R11

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DT_W-1:0] dead,
    input  logic            cmd_hi_s,
    input  logic            cmd_lo_s,
    input  hbg_flags_t      flags_s,
    input  logic            refresh,
    output logic            gate_hi_o,
    output logic            gate_lo_o
);

    typedef struct packed {
        logic [DT_W-1:0] hi_cnt;
        logic [DT_W-1:0] lo_cnt;
        logic            hi_on;
        logic            lo_on;
    } leg_state_t;

    leg_state_t st_q, st_d;
    hbg_req_t   req;

    // override ladder: disable / main UV, then refresh, then lower-wins
    always_comb begin
        req = '0;
        if (flags_s.dis || flags_s.uv_main) begin
            req = '0;
        end else if (refresh) begin
            req.lo = 1'b1;
        end else begin
            req.lo = cmd_lo_s;
            req.hi = cmd_hi_s && !cmd_lo_s && !flags_s.uv_high;
        end
    end

    // per-gate dead-time counters, reloaded while the gate may not start
    always_comb begin
        st_d = st_q;

        if (!req.lo || st_q.hi_on)       st_d.lo_cnt = dead;
        else if (st_q.lo_cnt != '0)      st_d.lo_cnt = st_q.lo_cnt - DT_W'(1);

        if (!req.hi || st_q.lo_on)       st_d.hi_cnt = dead;
        else if (st_q.hi_cnt != '0)      st_d.hi_cnt = st_q.hi_cnt - DT_W'(1);

        st_d.lo_on = req.lo && !st_q.hi_on && (st_q.lo_cnt == '0);
        st_d.hi_on = req.hi && !st_q.lo_on && (st_q.hi_cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_hi_o = st_q.hi_on;
    assign gate_lo_o = st_q.lo_on;

    AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hi_on && st_q.lo_on));  // R3

    AST_LO_OFF_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
        !req.lo |=> !st_q.lo_on);  // R5

    AST_HI_OFF_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
        !req.hi |=> !st_q.hi_on);  // R5

    AST_HI_AFTER_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hi_on) |-> !st_q.lo_on && !$past(st_q.lo_on));  // R10

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int DT_W        = 10,
    parameter int REFRESH_CYC = 72,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DT_W-1:0] dead_cyc,
    input  logic [1:0]      cmd_hi,
    input  logic [1:0]      cmd_lo,
    input  logic            dis,
    input  logic            uv_main,
    input  logic            uv_high,
    output logic [1:0]      gate_hi,
    output logic [1:0]      gate_lo
);

    localparam int SYNC_W = 2 * NUM_LEGS + 3;

    typedef struct packed {
        logic [DT_W-1:0] dead;
    } top_state_t;

    top_state_t           st_q, st_d;
    logic [SYNC_W-1:0]    raw_in, sync_out;
    logic [NUM_LEGS-1:0]  cmd_hi_s, cmd_lo_s;
    hbg_flags_t           flags_s;
    logic                 refresh;

    assign raw_in = {dis, uv_main, uv_high, cmd_hi, cmd_lo};

    hbg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_out)
    );

    assign flags_s  = hbg_flags_t'(sync_out[SYNC_W-1 -: 3]);
    assign cmd_hi_s = sync_out[2*NUM_LEGS-1 -: NUM_LEGS];
    assign cmd_lo_s = sync_out[NUM_LEGS-1:0];

    always_comb begin
        st_d      = st_q;
        st_d.dead = dead_cyc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    hbg_refresh #(.DT_W(DT_W), .REFRESH_CYC(REFRESH_CYC)) u_refresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .dis_s     (flags_s.dis),
        .dead      (st_q.dead),
        .refresh_o (refresh)
    );

    generate
        for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
            hbg_leg #(.DT_W(DT_W)) u_leg (
                .clk       (clk),
                .rst_n     (rst_n),
                .dead      (st_q.dead),
                .cmd_hi_s  (cmd_hi_s[g]),
                .cmd_lo_s  (cmd_lo_s[g]),
                .flags_s   (flags_s),
                .refresh   (refresh),
                .gate_hi_o (gate_hi[g]),
                .gate_lo_o (gate_lo[g])
            );
        end
    endgenerate

    AST_DIS_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flags_s.dis) |-> (gate_hi == '0 && gate_lo == '0));  // R1

    AST_UV_MAIN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flags_s.uv_main) |-> (gate_hi == '0 && gate_lo == '0));  // R2

    AST_UV_HIGH_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flags_s.uv_high) |-> (gate_hi == '0));  // R4

    AST_REFRESH_NO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(refresh) |-> (gate_hi == '0));  // R9

endmodule

// File: tb/sim_hbridge_gate_ctrl.sv
`timescale 1ns/1ps
module sim_hbridge_gate_ctrl;

    localparam int DT_W = 10;
    localparam int DT   = 5;
    localparam int REF  = 72;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [DT_W-1:0] dead_cyc = DT_W'(DT);
    logic [1:0]      cmd_hi = '0;
    logic [1:0]      cmd_lo = '0;
    logic            dis = 1'b0;
    logic            uv_main = 1'b0;
    logic            uv_high = 1'b0;
    logic [1:0]      gate_hi, gate_lo;
    logic [3:0]      outs;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #4 clk = ~clk;  // 125 MHz

    hbridge_gate_ctrl #(.DT_W(DT_W), .REFRESH_CYC(REF)) u0 (
        .clk(clk), .rst_n(rst_n), .dead_cyc(dead_cyc),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .dis(dis),
        .uv_main(uv_main), .uv_high(uv_high),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // outs = {hi1, hi0, lo1, lo0}
    assign outs = {gate_hi, gate_lo};

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wait_for(input logic [3:0] want, input int maxc, output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (outs != want && n < maxc);
    endtask

    task automatic wait_while(input logic [3:0] hold, input int maxc, output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (outs == hold && n < maxc);
    endtask

    task automatic t_reset();
        chk(outs == 4'b0000, "R12 outputs low in reset", outs, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(5);
        chk(outs == 4'b0000, "R12 outputs low after reset", outs, 0);
    endtask

    task automatic t_on_off();
        int n;
        @(negedge clk); cmd_lo = 2'b01;
        wait_for(4'b0001, 50, n);
        chk(n == DT + 3, "R6 lower turn-on latency", n, DT + 3);
        @(negedge clk); cmd_lo = 2'b00;
        wait_for(4'b0000, 50, n);
        chk(n == 3, "R5 lower turn-off latency", n, 3);
        idle(10);
    endtask

    task automatic t_lower_wins_and_comp();
        int n;
        @(negedge clk); cmd_hi = 2'b01; cmd_lo = 2'b01;
        wait_for(4'b0001, 50, n);
        idle(20);
        chk(outs == 4'b0001, "R3 lower wins over upper", outs, 4'b0001);
        @(negedge clk); cmd_lo = 2'b00;
        wait_for(4'b0000, 50, n);
        chk(n == 3, "R7 lower falls on command", n, 3);
        wait_for(4'b0100, 50, n);
        chk(n == DT + 1, "R7 upper rises after gap", n, DT + 1);
        @(negedge clk); cmd_lo = 2'b01;
        wait_for(4'b0000, 50, n);
        chk(n == 3, "R7 upper falls on command", n, 3);
        wait_for(4'b0001, 50, n);
        chk(n == DT + 1, "R7 lower rises after gap", n, DT + 1);
        @(negedge clk); cmd_lo = 2'b00; cmd_hi = 2'b00;
        idle(20);
    endtask

    task automatic t_independent();
        int n;
        @(negedge clk); cmd_hi = 2'b01;
        wait_for(4'b0100, 50, n);
        @(negedge clk); cmd_lo = 2'b10;
        wait_for(4'b0110, 50, n);
        chk(n == DT + 3, "R8 leg1 lower latency unaffected", n, DT + 3);
        chk(outs[2] == 1'b1, "R8 leg0 upper held", outs[2], 1);
        @(negedge clk); cmd_lo = 2'b00;
        wait_for(4'b0100, 50, n);
        chk(n == 3, "R8 leg1 off, leg0 kept", n, 3);
        @(negedge clk); cmd_hi = 2'b00;
        idle(20);
    endtask

    task automatic t_uv_high();
        int n;
        @(negedge clk); cmd_hi = 2'b11;
        wait_for(4'b1100, 50, n);
        chk(n == DT + 3, "R6 both uppers turn on", n, DT + 3);
        @(negedge clk); uv_high = 1'b1; cmd_lo = 2'b10;
        wait_for(4'b0000, 50, n);
        chk(n == 3, "R4 uppers forced off", n, 3);
        wait_for(4'b0010, 50, n);
        chk(n == DT + 1, "R4 lower follows own command", n, DT + 1);
        idle(10);
        chk(outs == 4'b0010, "R4 upper0 held low", outs, 4'b0010);
        @(negedge clk); uv_high = 1'b0; cmd_lo = 2'b00; cmd_hi = 2'b00;
        idle(20);
    endtask

    task automatic t_uv_main();
        int n;
        @(negedge clk); cmd_lo = 2'b11;
        wait_for(4'b0011, 50, n);
        @(negedge clk); uv_main = 1'b1;
        wait_for(4'b0000, 50, n);
        chk(n == 3, "R2 main undervoltage clears gates", n, 3);
        idle(10);
        chk(outs == 4'b0000, "R2 gates stay low", outs, 0);
        @(negedge clk); uv_main = 1'b0;
        wait_for(4'b0011, 50, n);
        chk(n == DT + 3, "R6 lowers return after UV", n, DT + 3);
        @(negedge clk); cmd_lo = 2'b00;
        idle(20);
    endtask

    task automatic t_dis_refresh();
        int n;
        @(negedge clk); cmd_hi = 2'b11;
        wait_for(4'b1100, 50, n);
        @(negedge clk); dis = 1'b1;
        wait_for(4'b0000, 50, n);
        chk(n == 3, "R1 disable clears gates", n, 3);
        @(negedge clk); cmd_lo = 2'b01;
        idle(10);
        chk(outs == 4'b0000, "R1 commands ignored in disable", outs, 0);
        @(negedge clk); cmd_hi = 2'b00; cmd_lo = 2'b00;
        idle(5);
        @(negedge clk); dis = 1'b0;
        wait_for(4'b0011, 200, n);
        chk(n == DT + 3, "R9 refresh start latency", n, DT + 3);
        wait_while(4'b0011, 500, n);
        chk(n == REF, "R9 refresh pulse width", n, REF);
        chk(outs == 4'b0000, "R9 all low after refresh", outs, 0);
        idle(10);
    endtask

    task automatic t_refresh_upper();
        int n;
        @(negedge clk); cmd_hi = 2'b01; dis = 1'b1;
        idle(10);
        @(negedge clk); dis = 1'b0;
        wait_for(4'b0011, 200, n);
        chk(n == DT + 3, "R9 refresh with upper pending", n, DT + 3);
        wait_while(4'b0011, 500, n);
        chk(n == REF && outs == 4'b0000, "R10 refresh ends, all low", outs, 0);
        wait_for(4'b0100, 50, n);
        chk(n == DT + 1, "R10 upper after refresh gap", n, DT + 1);
        @(negedge clk); cmd_hi = 2'b00;
        idle(20);
    endtask

    task automatic t_abort();
        int n;
        @(negedge clk); dis = 1'b1;
        idle(10);
        @(negedge clk); dis = 1'b0;
        wait_for(4'b0011, 200, n);
        idle(4);
        @(negedge clk); dis = 1'b1;
        wait_for(4'b0000, 50, n);
        chk(n == 3, "R11 refresh aborted by disable", n, 3);
        idle(REF + 10);
        chk(outs == 4'b0000, "R11 stays low after abort", outs, 0);
        @(negedge clk); dis = 1'b0;
        wait_for(4'b0011, 200, n);
        wait_while(4'b0011, 500, n);
        idle(10);
    endtask

    task automatic t_zero_dead();
        int n;
        @(negedge clk); dead_cyc = '0;
        idle(4);
        @(negedge clk); cmd_lo = 2'b10;
        wait_for(4'b0010, 50, n);
        chk(n == 3, "R13 zero dead time latency", n, 3);
        @(negedge clk); cmd_lo = 2'b00;
        idle(10);
        dead_cyc = DT_W'(DT);
    endtask

    initial begin
        idle(3);
        t_reset();
        t_on_off();
        t_lower_wins_and_comp();
        t_independent();
        t_uv_high();
        t_uv_main();
        t_dis_refresh();
        t_refresh_upper();
        t_abort();
        t_zero_dead();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule